// File: doc/BRIEF.md
# Memory-Mapped Serial NOR Flash Read Controller

This block is a bus slave that places a serial NOR flash in the processor's address space. A read of the memory region becomes a complete flash read transaction on the serial pins: the read opcode goes out on one line, then the address on one line, then a programmable number of idle (dummy) clocks, then one data word is collected on one, two or four lines. The bus acknowledge is held back until the final data bit has been captured, so the processor sees an ordinary slow read.

Software configures the transaction through a small register region. One register holds the read opcode, the dummy clock count, the lane mode and the clock divider. A second register lets software hold chip select low, and a third clocks one byte out on a single line while capturing the byte returned, so that any command (status read, identification, write enable) can be built from software. A build-time parameter chooses whether the controller wakes up with a single-line or a four-line read setup.

The controller is one state machine with states ST_IDLE, ST_CMD, ST_ADDR, ST_DUMMY, ST_DATA, ST_DEND, ST_MBYTE, ST_MEND and ST_ACK. From ST_IDLE a memory read goes to ST_CMD; a register access, a rejected access or an error goes to ST_ACK; a byte write with chip select held goes to ST_MBYTE. ST_CMD moves to ST_ADDR on the falling edge after its eighth clock; ST_ADDR moves to ST_DUMMY (dummy count non-zero) or straight to ST_DATA; ST_DUMMY moves to ST_DATA when its count is spent; ST_DATA moves to ST_DEND on the rising edge that samples the final bit; ST_MBYTE moves to ST_MEND on its eighth rising edge; ST_DEND and ST_MEND move to ST_ACK on the next falling edge; ST_ACK always returns to ST_IDLE.

Top module: `sflash_ctrl`

## Requirements
- R1: After reset the chip select output is high, the serial clock is low, no data line is driven and no acknowledge is given.
- R2: A memory read drives chip select low for the whole transaction and sends, most significant bit first on line 0, the 8-bit opcode, then the 24-bit byte address, then the configured dummy clocks, then the data clocks; the total clock count is 8 + 24 + dummy + 32/lanes.
- R3: The configuration register holds the opcode in bits 7:0, dummy clocks in bits 11:8, lane mode in bits 13:12 and divider in bits 19:16. Lane mode 0 samples line 1 only; mode 1 samples lines 1:0 with line 1 as the higher bit; mode 2 samples lines 3:0 with line 3 as the highest; mode 3 behaves as mode 0. The word is assembled most significant bit first.
- R4: The serial clock idles low and has a period of 2*(divider+1) system clocks, high for divider+1 of them.
- R5: Line 0 changes only on falling serial clock edges and input lines are sampled on rising edges.
- R6: In lane modes 1 and 2 all data line drivers are released during the dummy clocks and the data clocks.
- R7: A memory read is acknowledged 2*N*(divider+1)+1 cycles after the request was first presented (N the total serial clocks); a register access is acknowledged one cycle after; the acknowledge is a single-cycle pulse.
- R8: A write to the memory region is acknowledged with the error flag and causes no flash activity.
- R9: Bit 0 of the manual control register (offset 4) holds chip select low while set and reads back.
- R10: A write to the manual data register (offset 8) while chip select is held sends bits 7:0 on line 0, most significant first, and captures eight bits from line 1; the captured byte is returned on the write acknowledge and by reading that register.
- R11: A memory read while manual chip select is held is acknowledged with the error flag and produces no serial clocks.
- R12: A write to the manual data register while chip select is not held is acknowledged with the error flag and produces no serial clocks.
- R13: With the single-line build default the configuration register resets to opcode 0x03, no dummy clocks, lane mode 0 and the divider given by the build parameter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| bus_req | input | 1 | Access request, held until acknowledged |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_reg_sel | input | 1 | 1 = register region, 0 = flash memory region |
| bus_addr | input | ADDR_BITS | Flash byte address, or register offset in bits 3:2 |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | DATA_BITS | Read data, valid with the acknowledge |
| bus_ack | output | 1 | Single-cycle completion pulse |
| bus_err | output | 1 | Access rejected, valid with the acknowledge |
| spi_clk | output | 1 | Serial clock |
| spi_cs_n | output | 1 | Chip select, active low |
| spi_io_o | output | 4 | Data line output values |
| spi_io_oe | output | 4 | Data line output enables |
| spi_io_i | input | 4 | Data line input values |

## Verification
A request presented before a clock edge is taken at that edge, so a register access acknowledges at the first sampling point after it and a memory read at point 2*N*(divider+1)+1, where N follows from the opcode, address, dummy and lane settings; the bench counts sampling points from presentation to acknowledge and compares with that figure for every divider and lane mode it uses. A bench flash model captures opcode and address on rising serial edges and drives data chunks on falling edges, so correct read data and a correct clock count show both edge rules hold. The serial clock high time and period are timed between edges, data-line contention is checked half a cycle away from every active edge, and rejected accesses are checked by counting chip select falls and serial clocks before and after.

// File: rtl/sflash_pkg.sv
package sflash_pkg;

    localparam int DIV_W   = 4;
    localparam int DUMMY_W = 4;

    typedef enum logic [1:0] {
        LANE_X1   = 2'b00,
        LANE_X2   = 2'b01,
        LANE_X4   = 2'b10,
        LANE_RSVD = 2'b11
    } lane_e;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_CMD,
        ST_ADDR,
        ST_DUMMY,
        ST_DATA,
        ST_DEND,
        ST_MBYTE,
        ST_MEND,
        ST_ACK
    } state_e;

    typedef struct packed {
        logic [DIV_W-1:0]   div;
        lane_e              lanes;
        logic [DUMMY_W-1:0] dummy;
        logic [7:0]         opcode;
    } cfg_t;

    localparam logic [1:0] REG_CFG   = 2'd0;
    localparam logic [1:0] REG_MCTL  = 2'd1;
    localparam logic [1:0] REG_MDATA = 2'd2;

    function automatic int unsigned lane_count(input lane_e m);
        case (m)
            LANE_X2: lane_count = 2;
            LANE_X4: lane_count = 4;
            default: lane_count = 1;
        endcase
    endfunction

endpackage

// File: rtl/sflash_clkgen.sv
module sflash_clkgen #(
    parameter int DIV_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             sclk,
    output logic             rise,
    output logic             fall
);
    logic [DIV_W-1:0] cnt_q;
    logic             sclk_q;
    logic             edge_now;

    assign edge_now = run && (cnt_q == div);
    assign rise     = edge_now && !sclk_q;
    assign fall     = edge_now && sclk_q;
    assign sclk     = sclk_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            sclk_q <= 1'b0;
        end else if (!run) begin
            cnt_q  <= '0;
            sclk_q <= 1'b0;
        end else if (edge_now) begin
            cnt_q  <= '0;
            sclk_q <= ~sclk_q;
        end else begin
            cnt_q  <= cnt_q + 1'b1;
        end
    end

    AST_CLK_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> !sclk_q); // R4

    AST_HALF_PERIOD_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (run && $past(run)) |-> (cnt_q <= div)); // R4

endmodule

// File: rtl/sflash_shifter.sv
module sflash_shifter
    import sflash_pkg::*;
#(
    parameter int SR_W = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load,
    input  logic [SR_W-1:0] load_val,
    input  logic            shift_out,
    input  logic            shift_in,
    input  lane_e           lanes,
    input  logic [3:0]      io_i,
    output logic            tx_bit,
    output logic [SR_W-1:0] rx_next
);
    logic [SR_W-1:0] tx_q;
    logic [SR_W-1:0] rx_q;

    assign tx_bit = tx_q[SR_W-1];

    always_comb begin
        unique case (lanes)
            LANE_X2: rx_next = {rx_q[SR_W-3:0], io_i[1:0]};
            LANE_X4: rx_next = {rx_q[SR_W-5:0], io_i[3:0]};
            default: rx_next = {rx_q[SR_W-2:0], io_i[1]};
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_q <= '0;
            rx_q <= '0;
        end else begin
            if (load)           tx_q <= load_val;
            else if (shift_out) tx_q <= {tx_q[SR_W-2:0], 1'b0};
            if (load)           rx_q <= '0;
            else if (shift_in)  rx_q <= rx_next;
        end
    end

    AST_TX_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(load) && !$past(shift_out)) |-> $stable(tx_bit)); // R5

endmodule

// File: rtl/sflash_ctrl.sv
module sflash_ctrl
    import sflash_pkg::*;
#(
    parameter int ADDR_BITS    = 24,
    parameter int DATA_BITS    = 32,
    parameter bit QUAD_DEFAULT = 1'b0,
    parameter int DIV_DEFAULT  = 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bus_req,
    input  logic                 bus_we,
    input  logic                 bus_reg_sel,
    input  logic [ADDR_BITS-1:0] bus_addr,
    input  logic [31:0]          bus_wdata,
    output logic [DATA_BITS-1:0] bus_rdata,
    output logic                 bus_ack,
    output logic                 bus_err,
    output logic                 spi_clk,
    output logic                 spi_cs_n,
    output logic [3:0]           spi_io_o,
    output logic [3:0]           spi_io_oe,
    input  logic [3:0]           spi_io_i
);
    localparam int SR_W    = (ADDR_BITS > DATA_BITS) ? ADDR_BITS : DATA_BITS;
    localparam int CNT_MAX = SR_W;
    localparam int CNT_W   = $clog2(CNT_MAX + 1);

    localparam cfg_t CFG_RESET = '{
        div:    DIV_W'(DIV_DEFAULT),
        lanes:  QUAD_DEFAULT ? LANE_X4 : LANE_X1,
        dummy:  QUAD_DEFAULT ? DUMMY_W'(8) : DUMMY_W'(0),
        opcode: QUAD_DEFAULT ? 8'h6B : 8'h03
    };

    state_e               state_q, state_d;
    cfg_t                 cfg_q;
    logic                 man_cs_q;
    logic [7:0]           mrx_q;
    logic [ADDR_BITS-1:0] addr_q;
    logic [CNT_W-1:0]     cnt_q;
    logic                 ack_q, err_q;
    logic [DATA_BITS-1:0] rdata_q;

    logic                 sr_load;
    logic [SR_W-1:0]      sr_val;
    logic                 cnt_ld;
    logic [CNT_W-1:0]     cnt_val;
    logic                 ack_set, err_set, rdata_set;
    logic [DATA_BITS-1:0] rdata_val;
    logic                 cfg_we, mctl_we, mrx_we, addr_ld;

    logic                 busy, release_io, run;
    logic                 rise, fall, sclk, tx_bit;
    lane_e                rx_lanes;
    logic [SR_W-1:0]      rx_next;
    logic [1:0]           reg_idx;
    logic [31:0]          reg_word;
    logic [CNT_W-1:0]     data_clks;
    logic                 unused_bits;

    assign unused_bits = ^{bus_wdata[31:20], bus_wdata[15:14]};
    assign reg_idx     = bus_addr[3:2];
    assign data_clks   = CNT_W'(DATA_BITS / lane_count(cfg_q.lanes));
    assign rx_lanes    = (state_q == ST_DATA) ? cfg_q.lanes : LANE_X1;
    assign run         = busy;

    sflash_clkgen #(.DIV_W(DIV_W)) u_clkgen (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (run),
        .div   (cfg_q.div),
        .sclk  (sclk),
        .rise  (rise),
        .fall  (fall)
    );

    sflash_shifter #(.SR_W(SR_W)) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (sr_load),
        .load_val  (sr_val),
        .shift_out (fall && !sr_load),
        .shift_in  (rise),
        .lanes     (rx_lanes),
        .io_i      (spi_io_i),
        .tx_bit    (tx_bit),
        .rx_next   (rx_next)
    );

    always_comb begin
        case (reg_idx)
            REG_CFG:   reg_word = {12'b0, cfg_q.div, 2'b0, cfg_q.lanes, cfg_q.dummy, cfg_q.opcode};
            REG_MCTL:  reg_word = {31'b0, man_cs_q};
            REG_MDATA: reg_word = {24'b0, mrx_q};
            default:   reg_word = '0;
        endcase
    end

    // next-state and datapath control
    always_comb begin
        state_d   = state_q;
        sr_load   = 1'b0;
        sr_val    = '0;
        cnt_ld    = 1'b0;
        cnt_val   = '0;
        ack_set   = 1'b0;
        err_set   = 1'b0;
        rdata_set = 1'b0;
        rdata_val = '0;
        cfg_we    = 1'b0;
        mctl_we   = 1'b0;
        mrx_we    = 1'b0;
        addr_ld   = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (bus_req) begin
                    if (bus_reg_sel) begin
                        if (bus_we && reg_idx == REG_MDATA) begin
                            if (man_cs_q) begin
                                sr_load = 1'b1;
                                sr_val  = {bus_wdata[7:0], {(SR_W-8){1'b0}}};
                                cnt_ld  = 1'b1;
                                cnt_val = CNT_W'(8);
                                state_d = ST_MBYTE;
                            end else begin
                                ack_set = 1'b1;
                                err_set = 1'b1;
                                state_d = ST_ACK;
                            end
                        end else begin
                            ack_set   = 1'b1;
                            rdata_set = 1'b1;
                            rdata_val = DATA_BITS'(reg_word);
                            cfg_we    = bus_we && (reg_idx == REG_CFG);
                            mctl_we   = bus_we && (reg_idx == REG_MCTL);
                            state_d   = ST_ACK;
                        end
                    end else if (bus_we || man_cs_q) begin
                        ack_set   = 1'b1;
                        err_set   = 1'b1;
                        rdata_set = 1'b1;
                        state_d   = ST_ACK;
                    end else begin
                        sr_load = 1'b1;
                        sr_val  = {cfg_q.opcode, {(SR_W-8){1'b0}}};
                        cnt_ld  = 1'b1;
                        cnt_val = CNT_W'(8);
                        addr_ld = 1'b1;
                        state_d = ST_CMD;
                    end
                end
            end
            ST_CMD: begin
                if (fall && cnt_q == '0) begin
                    sr_load = 1'b1;
                    sr_val  = {addr_q, {(SR_W-ADDR_BITS){1'b0}}};
                    cnt_ld  = 1'b1;
                    cnt_val = CNT_W'(ADDR_BITS);
                    state_d = ST_ADDR;
                end
            end
            ST_ADDR: begin
                if (fall && cnt_q == '0) begin
                    cnt_ld = 1'b1;
                    if (cfg_q.dummy != '0) begin
                        cnt_val = CNT_W'(cfg_q.dummy);
                        state_d = ST_DUMMY;
                    end else begin
                        cnt_val = data_clks;
                        state_d = ST_DATA;
                    end
                end
            end
            ST_DUMMY: begin
                if (fall && cnt_q == '0) begin
                    cnt_ld  = 1'b1;
                    cnt_val = data_clks;
                    state_d = ST_DATA;
                end
            end
            ST_DATA: begin
                if (rise && cnt_q == CNT_W'(1)) begin
                    rdata_set = 1'b1;
                    rdata_val = rx_next[DATA_BITS-1:0];
                    state_d   = ST_DEND;
                end
            end
            ST_MBYTE: begin
                if (rise && cnt_q == CNT_W'(1)) begin
                    rdata_set = 1'b1;
                    rdata_val = DATA_BITS'(rx_next[7:0]);
                    mrx_we    = 1'b1;
                    state_d   = ST_MEND;
                end
            end
            ST_DEND, ST_MEND: begin
                if (fall) begin
                    ack_set = 1'b1;
                    state_d = ST_ACK;
                end
            end
            ST_ACK:  state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // state register and datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            cfg_q    <= CFG_RESET;
            man_cs_q <= 1'b0;
            mrx_q    <= '0;
            addr_q   <= '0;
            cnt_q    <= '0;
            ack_q    <= 1'b0;
            err_q    <= 1'b0;
            rdata_q  <= '0;
        end else begin
            state_q <= state_d;
            ack_q   <= ack_set;
            err_q   <= err_set;
            if (rdata_set) rdata_q <= rdata_val;
            if (addr_ld)   addr_q  <= bus_addr;
            if (mrx_we)    mrx_q   <= rx_next[7:0];
            if (mctl_we)   man_cs_q <= bus_wdata[0];
            if (cfg_we) begin
                cfg_q.opcode <= bus_wdata[7:0];
                cfg_q.dummy  <= bus_wdata[11:8];
                cfg_q.lanes  <= lane_e'(bus_wdata[13:12]);
                cfg_q.div    <= bus_wdata[19:16];
            end
            if (cnt_ld)                  cnt_q <= cnt_val;
            else if (rise && cnt_q != '0) cnt_q <= cnt_q - 1'b1;
        end
    end

    // outputs
    always_comb begin
        busy = state_q inside {ST_CMD, ST_ADDR, ST_DUMMY, ST_DATA, ST_DEND, ST_MBYTE, ST_MEND};
        release_io = (state_q inside {ST_DUMMY, ST_DATA, ST_DEND}) &&
                     (cfg_q.lanes inside {LANE_X2, LANE_X4});
        spi_cs_n  = !(busy || man_cs_q);
        spi_clk   = sclk;
        spi_io_o  = {2'b11, 1'b0, tx_bit};
        spi_io_oe = (busy && !release_io) ? 4'b1101 : 4'b0000;
        bus_ack   = ack_q;
        bus_err   = err_q;
        bus_rdata = rdata_q;
    end

    AST_ACK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        bus_ack |=> !bus_ack); // R7

    AST_ERR_NEEDS_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        bus_err |-> bus_ack); // R8

    AST_CLK_UNDER_CS: assert property (@(posedge clk) disable iff (!rst_n)
        spi_clk |-> !spi_cs_n); // R2

    AST_WIDE_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DATA && cfg_q.lanes inside {LANE_X2, LANE_X4}) |-> (spi_io_oe == 4'b0000)); // R6

    AST_NO_DIRECT_IN_MANUAL: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_CMD) |-> !man_cs_q); // R11

    AST_LINE0_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy) && !$past(fall)) |-> $stable(spi_io_o[0])); // R5

endmodule

// File: tb/tb_sflash_ctrl.sv
module tb_sflash_ctrl;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        bus_req, bus_we, bus_reg_sel;
    logic [23:0] bus_addr;
    logic [31:0] bus_wdata;
    logic [31:0] bus_rdata;
    logic        bus_ack, bus_err;
    logic        spi_clk, spi_cs_n;
    logic [3:0]  spi_io_o, spi_io_oe, spi_io_i;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sflash_ctrl dut (
        .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we),
        .bus_reg_sel(bus_reg_sel), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .bus_ack(bus_ack), .bus_err(bus_err),
        .spi_clk(spi_clk), .spi_cs_n(spi_cs_n), .spi_io_o(spi_io_o),
        .spi_io_oe(spi_io_oe), .spi_io_i(spi_io_i)
    );

    // ---------------- flash model ----------------
    bit         man_model = 0;
    int         m_lanes = 1;
    int         m_dummy = 0;
    int         rises = 0;
    int         mbit = 0;
    logic [7:0] m_cmd, m_mrx;
    logic [7:0] m_mresp = 8'h5A;
    logic [23:0] m_addr;
    logic [3:0] m_oe = 4'b0000;
    logic [3:0] m_val = 4'b1111;
    int         contention = 0;
    int         cs_falls = 0;
    int         sclk_total = 0;
    longint     t_rise = 0, last_high = 0, last_period = 0;

    assign spi_io_i = (m_oe & m_val) | (~m_oe & spi_io_oe & spi_io_o) | (~m_oe & ~spi_io_oe);

    function automatic logic [31:0] word_of(input logic [23:0] a);
        return {a[7:0] ^ 8'hC3, a[23:16], a[15:8] ^ 8'h5A, ~a[7:0]};
    endfunction

    always @(negedge spi_cs_n) begin
        cs_falls++;
        rises = 0;
        m_cmd = '0;
        m_addr = '0;
        m_mrx = '0;
        if (man_model) begin
            m_oe = 4'b0010;
            m_val[1] = m_mresp[7];
            mbit = 1;
        end else begin
            m_oe = 4'b0000;
        end
    end

    always @(posedge spi_cs_n) m_oe = 4'b0000;

    always @(posedge spi_clk) begin
        sclk_total++;
        last_period = $time - t_rise;
        t_rise = $time;
        if (!spi_cs_n) begin
            if (man_model) m_mrx = {m_mrx[6:0], spi_io_o[0]};
            else if (rises < 8) m_cmd = {m_cmd[6:0], spi_io_o[0]};
            else if (rises < 32) m_addr = {m_addr[22:0], spi_io_o[0]};
            rises++;
        end
    end

    always @(negedge spi_clk) begin
        last_high = $time - t_rise;
        if (!spi_cs_n) begin
            if (man_model) begin
                if (mbit < 8) m_val[1] = m_mresp[7 - mbit];
                mbit++;
            end else if (rises >= 32 + m_dummy) begin
                int k;
                logic [31:0] w;
                logic [31:0] chunk;
                k = rises - (32 + m_dummy);
                w = word_of(m_addr);
                if (k < 32 / m_lanes) begin
                    chunk = (w >> (32 - m_lanes * (k + 1))) & ((32'd1 << m_lanes) - 1);
                    if (m_lanes == 1) begin m_oe = 4'b0010; m_val[1] = chunk[0]; end
                    else if (m_lanes == 2) begin m_oe = 4'b0011; m_val[1:0] = chunk[1:0]; end
                    else begin m_oe = 4'b1111; m_val = chunk[3:0]; end
                end else begin
                    m_oe = 4'b0000;
                end
            end
        end
    end

    always @(negedge clk) if ((m_oe & spi_io_oe) != 4'b0000) contention++;

    // ---------------- helpers ----------------
    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic bus_xfer(input logic sel, input logic we, input logic [23:0] a,
                            input logic [31:0] wd, output logic [31:0] rd,
                            output logic er, output int cyc);
        @(negedge clk);
        bus_req = 1'b1; bus_we = we; bus_reg_sel = sel; bus_addr = a; bus_wdata = wd;
        cyc = 0;
        do begin
            @(negedge clk);
            cyc++;
        end while (!bus_ack && cyc < 20000);
        rd = bus_rdata;
        er = bus_err;
        bus_req = 1'b0; bus_we = 1'b0;
    endtask

    int cur_div = 1;

    task automatic set_cfg(input logic [7:0] op, input int dummy, input int lanes, input int div);
        logic [31:0] rd; logic er; int cyc;
        bus_xfer(1'b1, 1'b1, 24'h0, {12'b0, 4'(div), 2'b0, 2'(lanes), 4'(dummy), op}, rd, er, cyc);
        chk("R7 register write ack latency", cyc, 1);
        cur_div = div;
    endtask

    // ---------------- scenarios ----------------
    task automatic t_reset;
        logic [31:0] rd; logic er; int cyc;
        chk("R1 cs_n after reset", spi_cs_n, 1);
        chk("R1 sclk after reset", spi_clk, 0);
        chk("R1 oe after reset", spi_io_oe, 0);
        chk("R1 ack after reset", bus_ack, 0);
        bus_xfer(1'b1, 1'b0, 24'h0, 32'h0, rd, er, cyc);
        chk("R13 default config", rd, 32'h0001_0003);
        chk("R7 register read ack latency", cyc, 1);
        @(negedge clk);
        chk("R7 ack is one pulse", bus_ack, 0);
    endtask

    task automatic t_direct(input string name, input logic [7:0] op, input int dummy,
                            input int lanes, input int div, input logic [23:0] a);
        logic [31:0] rd; logic er; int cyc; int nl; int n;
        set_cfg(op, dummy, lanes, div);
        nl = (lanes == 1) ? 2 : (lanes == 2) ? 4 : 1;
        m_lanes = nl; m_dummy = dummy; man_model = 0;
        contention = 0;
        n = 8 + 24 + dummy + 32 / nl;
        bus_xfer(1'b0, 1'b0, a, 32'h0, rd, er, cyc);
        chk({name, " R3 R5 read data"}, rd, word_of(a));
        chk({name, " R2 opcode on line 0"}, m_cmd, op);
        chk({name, " R2 address on line 0"}, m_addr, a);
        chk({name, " R2 total serial clocks"}, rises, n);
        chk({name, " R7 read ack latency"}, cyc, 2 * n * (div + 1) + 1);
        chk({name, " R8 no error on read"}, er, 0);
        chk({name, " R6 no line contention"}, contention, 0);
        chk({name, " R4 high time"}, 32'(last_high), 32'((div + 1) * CLK_PERIOD));
        chk({name, " R4 period"}, 32'(last_period), 32'(2 * (div + 1) * CLK_PERIOD));
        chk({name, " R2 cs_n released"}, spi_cs_n, 1);
    endtask

    task automatic t_mem_write;
        logic [31:0] rd; logic er; int cyc; int f0;
        f0 = cs_falls;
        bus_xfer(1'b0, 1'b1, 24'h000100, 32'hDEAD_BEEF, rd, er, cyc);
        chk("R8 memory write error", er, 1);
        chk("R8 memory write ack latency", cyc, 1);
        repeat (4) @(negedge clk);
        chk("R8 no chip select activity", cs_falls, f0);
    endtask

    task automatic t_manual;
        logic [31:0] rd; logic er; int cyc; int s0;
        man_model = 1;
        m_mresp = 8'h5A;
        bus_xfer(1'b1, 1'b1, 24'h4, 32'h1, rd, er, cyc);
        chk("R9 cs_n held low", spi_cs_n, 0);
        bus_xfer(1'b1, 1'b0, 24'h4, 32'h0, rd, er, cyc);
        chk("R9 hold bit reads back", rd, 32'h1);
        s0 = sclk_total;
        bus_xfer(1'b0, 1'b0, 24'h000040, 32'h0, rd, er, cyc);
        chk("R11 direct read rejected", er, 1);
        chk("R11 no serial clocks", sclk_total, s0);
        bus_xfer(1'b1, 1'b1, 24'h8, 32'h0000_009F, rd, er, cyc);
        chk("R10 byte sent on line 0", m_mrx, 8'h9F);
        chk("R10 byte returned on write", rd, 32'h5A);
        chk("R10 manual byte latency", cyc, 2 * 8 * (cur_div + 1) + 1);
        chk("R10 write not in error", er, 0);
        chk("R9 cs_n stays low after byte", spi_cs_n, 0);
        bus_xfer(1'b1, 1'b0, 24'h8, 32'h0, rd, er, cyc);
        chk("R10 received byte readback", rd, 32'h5A);
        bus_xfer(1'b1, 1'b1, 24'h4, 32'h0, rd, er, cyc);
        chk("R9 cs_n released", spi_cs_n, 1);
        man_model = 0;
    endtask

    task automatic t_manual_no_cs;
        logic [31:0] rd; logic er; int cyc; int s0;
        s0 = sclk_total;
        bus_xfer(1'b1, 1'b1, 24'h8, 32'h0000_00AB, rd, er, cyc);
        chk("R12 byte without cs rejected", er, 1);
        repeat (4) @(negedge clk);
        chk("R12 no serial clocks", sclk_total, s0);
        chk("R12 cs_n stays high", spi_cs_n, 1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0;
        bus_req = 1'b0; bus_we = 1'b0; bus_reg_sel = 1'b0;
        bus_addr = '0; bus_wdata = '0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_direct("single", 8'h03, 0, 0, 1, 24'h123456);
        t_direct("quad",   8'h6B, 6, 2, 0, 24'hABCDEF);
        t_direct("dual",   8'h3B, 8, 1, 2, 24'h00F0F1);
        t_direct("mode3",  8'h0B, 8, 3, 0, 24'hFFFFFC);
        t_mem_write();
        t_manual();
        t_manual_no_cs();
        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule